// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block turns a peripheral clock frequency (whole MHz) and a target bus rate (kHz) into the low and high times of the serial clock for an I2C master. A speed-class input picks standard-mode timing (equal low and high halves) or fast-mode timing. In fast mode a duty-select input picks a 2:1 or a 16:9 low-to-high ratio. The block also produces the rise-time limit count that goes with the chosen class. It raises a configuration error when the clock is out of range, the bus rate is out of range, or the divider does not fit its field.

The configuration is computed by a shared serial divider and committed only while the enable input is low. While enable is high the committed timing is frozen and the phase counter drives SCL. The counter always starts with a low phase. An external stretch input holds the low phase until it is released. Data, SDA and arbitration are handled elsewhere.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, scl is 1, div_val is 0, trise_cnt is 0, duty_flag is 0 and cfg_err is 0.
- R2: With fast_mode=0, div_val = floor(clk_mhz*1000 / (2*bus_khz)), duty_flag = 0, and scl runs with div_val clock cycles low and div_val cycles high. duty_169 has no effect in this class.
- R3: With fast_mode=0, a computed divider below 4 is replaced by 4.
- R4: With fast_mode=1 and duty_169=0, div_val = floor(clk_mhz*1000 / (3*bus_khz)), duty_flag = 0, and scl is low for 2*div_val cycles and high for div_val cycles.
- R5: With fast_mode=1 and duty_169=1, div_val = floor(clk_mhz*1000 / (25*bus_khz)), duty_flag = 1, and scl is low for 16*div_val cycles and high for 9*div_val cycles.
- R6: With fast_mode=1, a computed divider of 0 is replaced by 1.
- R7: A computed divider above 4095 sets cfg_err to 1, forces div_val, trise_cnt and duty_flag to 0, and keeps scl at 1 while enabled.
- R8: clk_mhz outside 2..36, or bus_khz outside 1..400, sets cfg_err with the same outputs as R7. The values 2, 36 and 400 themselves are accepted.
- R9: trise_cnt = clk_mhz + 1 with fast_mode=0, and floor(clk_mhz*3/10) + 1 with fast_mode=1.
- R10: The outputs div_val, trise_cnt, duty_flag and cfg_err are recomputed only while enable is 0, within 40 clock cycles of a change to the inputs. While enable is 1, changes to the configuration inputs have no effect on these outputs or on the scl timing.
- R11: While enable is 0, scl is 1 from the next clock cycle on. Once enable rises with a valid configuration, scl goes low on the next cycle.
- R12: A cycle with stretch=1 during a low phase adds one cycle to that low phase. stretch has no effect during a high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_mhz | input | 6 | Peripheral clock frequency in whole MHz |
| bus_khz | input | 9 | Target bus rate in kHz |
| fast_mode | input | 1 | 0 selects standard class, 1 selects fast class |
| duty_169 | input | 1 | In fast class: 0 selects 2:1, 1 selects 16:9 |
| enable | input | 1 | 1 runs SCL; 0 allows the configuration to update |
| stretch | input | 1 | Holds the low phase while 1 |
| scl | output | 1 | Serial clock level (1 = released high) |
| trise_cnt | output | 6 | Rise-time limit count |
| duty_flag | output | 1 | 1 when the 16:9 ratio is committed |
| div_val | output | 12 | Committed divider value |
| cfg_err | output | 1 | Configuration error |

## Verification
The divider is exercised in each ratio with clock and bus rate pairs that give exact and truncated quotients. These pairs show whether the per-class multiplier of 2, 3 or 25 is right. Small-quotient cases hit each class's clamp and separate the standard floor of 4 from the fast floor of 1. Measured low and high run lengths tell the three ratios apart even when they share a divider. Boundary values of clock and rate on both sides of each limit, along with quotients just above and below 4095, separate the range checks from the overflow check. Inputs changed while enabled, and stretch applied in each phase, show that the commit gate and the hold are confined to their intended windows.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    RATIO_1_1  = 2'd0,
    RATIO_2_1  = 2'd1,
    RATIO_16_9 = 2'd2
  } ratio_e;

  // divider units spent in the low phase for each ratio
  function automatic logic [4:0] low_units(ratio_e r);
    case (r)
      RATIO_2_1:  low_units = 5'd2;
      RATIO_16_9: low_units = 5'd16;
      default:    low_units = 5'd1;
    endcase
  endfunction

  // divider units spent in the high phase for each ratio
  function automatic logic [4:0] high_units(ratio_e r);
    case (r)
      RATIO_16_9: high_units = 5'd9;
      default:    high_units = 5'd1;
    endcase
  endfunction

  // bus-rate multiplier forming the divisor
  function automatic logic [4:0] rate_mult(ratio_e r);
    case (r)
      RATIO_2_1:  rate_mult = 5'd3;
      RATIO_16_9: rate_mult = 5'd25;
      default:    rate_mult = 5'd2;
    endcase
  endfunction

endpackage

// File: rtl/scl_divider.sv
// Restoring serial divider: one quotient bit per cycle.
module scl_divider #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int STEP_W = $clog2(NUM_W);

  logic              busy_q, busy_n;
  logic              done_q, done_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic [DEN_W-1:0]  den_q, den_n;
  logic [DEN_W-1:0]  rem_q, rem_n;
  logic [NUM_W-1:0]  qsh_q, qsh_n;
  logic [DEN_W:0]    trial;
  logic              fits;

  always_comb begin
    trial  = {rem_q, qsh_q[NUM_W-1]};
    fits   = (trial >= {1'b0, den_q});
    busy_n = busy_q;
    done_n = 1'b0;
    step_n = step_q;
    den_n  = den_q;
    rem_n  = rem_q;
    qsh_n  = qsh_q;
    if (busy_q) begin
      rem_n = fits ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
      qsh_n = {qsh_q[NUM_W-2:0], fits};
      if (step_q == STEP_W'(NUM_W - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        step_n = step_q + STEP_W'(1);
      end
    end else if (start) begin
      busy_n = 1'b1;
      step_n = '0;
      den_n  = den;
      rem_n  = '0;
      qsh_n  = num;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      qsh_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      step_q <= step_n;
      den_q  <= den_n;
      rem_q  <= rem_n;
      qsh_q  <= qsh_n;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = qsh_q;
endmodule

// File: rtl/scl_rise_calc.sv
// Rise-time limit count for the selected speed class.
module scl_rise_calc #(
  parameter int MHZ_W = 6
) (
  input  logic [MHZ_W-1:0] mhz,
  input  logic             fast,
  output logic [MHZ_W-1:0] trise
);
  logic [MHZ_W+1:0] scaled;

  always_comb begin
    scaled = ((MHZ_W+2)'(mhz) * (MHZ_W+2)'(3)) / (MHZ_W+2)'(10);
    if (fast) trise = MHZ_W'(scaled) + MHZ_W'(1);
    else      trise = mhz + MHZ_W'(1);
  end
endmodule

// File: rtl/scl_cfg_unit.sv
// Snapshots the inputs, runs the divider, clamps, checks and commits.
module scl_cfg_unit
  import scl_timing_pkg::*;
#(
  parameter int MHZ_W   = 6,
  parameter int KHZ_W   = 9,
  parameter int DIV_W   = 12,
  parameter int MHZ_MIN = 2,
  parameter int MHZ_MAX = 36,
  parameter int KHZ_MAX = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [MHZ_W-1:0] clk_mhz,
  input  logic [KHZ_W-1:0] bus_khz,
  input  logic             fast_mode,
  input  logic             duty_169,
  output logic [DIV_W-1:0] div_o,
  output ratio_e           ratio_o,
  output logic [MHZ_W-1:0] trise_o,
  output logic             err_o,
  output logic             valid_o
);
  localparam int NUM_W = MHZ_W + 10;
  localparam int DEN_W = KHZ_W + 5;

  ratio_e           ratio_live, ratio_s_q, ratio_s_n;
  logic [MHZ_W-1:0] mhz_s_q, mhz_s_n;
  logic [KHZ_W-1:0] khz_s_q, khz_s_n;
  logic [NUM_W-1:0] num_c, quo;
  logic [DEN_W-1:0] den_c;
  logic             start, dbusy, ddone, commit;
  logic             range_bad, ovf;
  logic [DIV_W-1:0] floor_v, div_clamped;
  logic [MHZ_W-1:0] trise_c;

  logic [DIV_W-1:0] div_q, div_n;
  ratio_e           ratio_q, ratio_n;
  logic [MHZ_W-1:0] trise_q, trise_n;
  logic             err_q, err_n, valid_q, valid_n;

  always_comb begin
    if (!fast_mode)    ratio_live = RATIO_1_1;
    else if (duty_169) ratio_live = RATIO_16_9;
    else               ratio_live = RATIO_2_1;
    num_c = NUM_W'(clk_mhz) * NUM_W'(1000);
    den_c = DEN_W'(bus_khz) * DEN_W'(rate_mult(ratio_live));
    start = !enable && !dbusy && !ddone;
  end

  scl_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .num   (num_c),
    .den   (den_c),
    .busy  (dbusy),
    .done  (ddone),
    .quo   (quo)
  );

  scl_rise_calc #(.MHZ_W(MHZ_W)) u_rise (
    .mhz   (mhz_s_q),
    .fast  (ratio_s_q != RATIO_1_1),
    .trise (trise_c)
  );

  always_comb begin
    mhz_s_n   = start ? clk_mhz    : mhz_s_q;
    khz_s_n   = start ? bus_khz    : khz_s_q;
    ratio_s_n = start ? ratio_live : ratio_s_q;

    commit    = ddone && !enable;
    range_bad = (int'(mhz_s_q) < MHZ_MIN) || (int'(mhz_s_q) > MHZ_MAX) ||
                (khz_s_q == '0) || (int'(khz_s_q) > KHZ_MAX);
    ovf       = |quo[NUM_W-1:DIV_W];
    floor_v   = (ratio_s_q == RATIO_1_1) ? DIV_W'(4) : DIV_W'(1);
    div_clamped = (quo < NUM_W'(floor_v)) ? floor_v : quo[DIV_W-1:0];

    div_n   = div_q;
    ratio_n = ratio_q;
    trise_n = trise_q;
    err_n   = err_q;
    valid_n = valid_q;
    if (commit) begin
      if (range_bad || ovf) begin
        div_n   = '0;
        ratio_n = RATIO_1_1;
        trise_n = '0;
        err_n   = 1'b1;
        valid_n = 1'b0;
      end else begin
        div_n   = div_clamped;
        ratio_n = ratio_s_q;
        trise_n = trise_c;
        err_n   = 1'b0;
        valid_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mhz_s_q   <= '0;
      khz_s_q   <= '0;
      ratio_s_q <= RATIO_1_1;
      div_q     <= '0;
      ratio_q   <= RATIO_1_1;
      trise_q   <= '0;
      err_q     <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      mhz_s_q   <= mhz_s_n;
      khz_s_q   <= khz_s_n;
      ratio_s_q <= ratio_s_n;
      div_q     <= div_n;
      ratio_q   <= ratio_n;
      trise_q   <= trise_n;
      err_q     <= err_n;
      valid_q   <= valid_n;
    end
  end

  assign div_o   = div_q;
  assign ratio_o = ratio_q;
  assign trise_o = trise_q;
  assign err_o   = err_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/scl_phase_gen.sv
// Low/high phase counter with low-phase hold.
module scl_phase_gen
  import scl_timing_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int CNT_W = DIV_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_ok,
  input  logic             stretch,
  input  logic [DIV_W-1:0] div,
  input  ratio_e           ratio,
  output logic             scl
);
  logic [CNT_W-1:0] low_len, high_len;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n;
  logic             hi_q, hi_n;

  always_comb begin
    low_len  = CNT_W'(low_units(ratio))  * CNT_W'(div);
    high_len = CNT_W'(high_units(ratio)) * CNT_W'(div);
    run_n = run_q;
    hi_n  = hi_q;
    cnt_n = cnt_q;
    if (!enable || !cfg_ok) begin
      run_n = 1'b0;
      hi_n  = 1'b0;
      cnt_n = '0;
    end else if (!run_q) begin
      run_n = 1'b1;
      hi_n  = 1'b0;
      cnt_n = '0;
    end else if (!hi_q) begin
      if (!stretch) begin
        if (cnt_q == low_len - CNT_W'(1)) begin
          hi_n  = 1'b1;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
    end else begin
      if (cnt_q == high_len - CNT_W'(1)) begin
        hi_n  = 1'b0;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      hi_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_n;
      hi_q  <= hi_n;
      cnt_q <= cnt_n;
    end
  end

  assign scl = !(run_q && !hi_q);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int MHZ_W   = 6,
  parameter int KHZ_W   = 9,
  parameter int DIV_W   = 12,
  parameter int MHZ_MIN = 2,
  parameter int MHZ_MAX = 36,
  parameter int KHZ_MAX = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MHZ_W-1:0] clk_mhz,
  input  logic [KHZ_W-1:0] bus_khz,
  input  logic             fast_mode,
  input  logic             duty_169,
  input  logic             enable,
  input  logic             stretch,
  output logic             scl,
  output logic [MHZ_W-1:0] trise_cnt,
  output logic             duty_flag,
  output logic [DIV_W-1:0] div_val,
  output logic             cfg_err
);
  localparam int CNT_W = DIV_W + 5;

  ratio_e cfg_ratio;
  logic   cfg_valid;

  scl_cfg_unit #(
    .MHZ_W(MHZ_W), .KHZ_W(KHZ_W), .DIV_W(DIV_W),
    .MHZ_MIN(MHZ_MIN), .MHZ_MAX(MHZ_MAX), .KHZ_MAX(KHZ_MAX)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .clk_mhz   (clk_mhz),
    .bus_khz   (bus_khz),
    .fast_mode (fast_mode),
    .duty_169  (duty_169),
    .div_o     (div_val),
    .ratio_o   (cfg_ratio),
    .trise_o   (trise_cnt),
    .err_o     (cfg_err),
    .valid_o   (cfg_valid)
  );

  scl_phase_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .cfg_ok  (cfg_valid),
    .stretch (stretch),
    .div     (div_val),
    .ratio   (cfg_ratio),
    .scl     (scl)
  );

  assign duty_flag = (cfg_ratio == RATIO_16_9);
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk
  import scl_timing_pkg::*;
#(
  parameter int MHZ_W = 6,
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             stretch,
  input logic             scl,
  input logic             cfg_err,
  input logic [DIV_W-1:0] div_val,
  input logic [MHZ_W-1:0] trise_cnt,
  input logic             duty_flag,
  input logic             cfg_valid,
  input ratio_e           cfg_ratio
);
  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> scl);

  assert_frozen_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(div_val) && $stable(trise_cnt) && $stable(cfg_err)
                && $stable(duty_flag)));

  assert_err_no_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> scl);

  assert_std_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ratio == RATIO_1_1) |-> (div_val >= DIV_W'(4)));

  assert_fast_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (div_val != '0));

  assert_hold_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stretch && !scl) |=> !scl);
endmodule

bind scl_timing_gen scl_timing_chk #(.MHZ_W(MHZ_W), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .stretch   (stretch),
  .scl       (scl),
  .cfg_err   (cfg_err),
  .div_val   (div_val),
  .trise_cnt (trise_cnt),
  .duty_flag (duty_flag),
  .cfg_valid (cfg_valid),
  .cfg_ratio (cfg_ratio)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  clk_mhz;
  logic [8:0]  bus_khz;
  logic        fast_mode, duty_169, enable, stretch;
  logic        scl, duty_flag, cfg_err;
  logic [5:0]  trise_cnt;
  logic [11:0] div_val;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  scl_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .clk_mhz(clk_mhz), .bus_khz(bus_khz),
    .fast_mode(fast_mode), .duty_169(duty_169), .enable(enable),
    .stretch(stretch), .scl(scl), .trise_cnt(trise_cnt),
    .duty_flag(duty_flag), .div_val(div_val), .cfg_err(cfg_err)
  );

  // columns: mhz, khz, fast, d169, div, trise, duty, err, low, high (0 = not timed)
  localparam int NV = 18;
  localparam int TV [NV][10] = '{
    '{ 8, 100, 0, 0,   40,  9, 0, 0,  40, 40},  // R2
    '{ 8, 100, 0, 1,   40,  9, 0, 0,  40, 40},  // R2 duty ignored
    '{ 8, 400, 0, 0,   10,  9, 0, 0,  10, 10},  // R2
    '{ 2, 400, 0, 0,    4,  3, 0, 0,   4,  4},  // R3 clamp
    '{36, 400, 1, 0,   30, 11, 0, 0,  60, 30},  // R4 R9
    '{ 4, 400, 1, 0,    3,  2, 0, 0,   6,  3},  // R4
    '{10, 100, 1, 0,   33,  4, 0, 0,  66, 33},  // R4 truncation
    '{36, 400, 1, 1,    3, 11, 1, 0,  48, 27},  // R5
    '{ 2, 400, 1, 1,    1,  1, 1, 0,  16,  9},  // R6 clamp
    '{36,   1, 0, 0,    0,  0, 0, 1,   0,  0},  // R7
    '{36,   4, 0, 0,    0,  0, 0, 1,   0,  0},  // R7 4500
    '{36,   5, 0, 0, 3600, 37, 0, 0,   0,  0},  // R7 fits
    '{ 1, 100, 0, 0,    0,  0, 0, 1,   0,  0},  // R8 low clock
    '{37, 100, 0, 0,    0,  0, 0, 1,   0,  0},  // R8 high clock
    '{ 2, 100, 0, 0,   10,  3, 0, 0,  10, 10},  // R8 edge accepted
    '{20,   0, 1, 0,    0,  0, 0, 1,   0,  0},  // R8 zero rate
    '{20, 401, 1, 0,    0,  0, 0, 1,   0,  0},  // R8 rate too high
    '{20, 400, 1, 1,    2,  7, 1, 0,  32, 18}   // R9 R5
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int m, input int k, input int f, input int d);
    @(negedge clk);
    clk_mhz = 6'(m); bus_khz = 9'(k); fast_mode = f[0]; duty_169 = d[0];
    repeat (60) @(negedge clk);
  endtask

  // raise enable, count the first low run and the following high run
  task automatic measure(output int lo, output int hi);
    enable = 1'b1;
    lo = 0; hi = 0;
    @(negedge clk);
    while (!scl) begin lo++; @(negedge clk); end
    while (scl && hi < 100000) begin hi++; @(negedge clk); end
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int lo, hi;
    rst_n = 1'b0; clk_mhz = '0; bus_khz = '0; fast_mode = 0; duty_169 = 0;
    enable = 0; stretch = 0;
    repeat (3) @(negedge clk);
    check("R1 scl", scl, 1);
    check("R1 div", div_val, 0);
    check("R1 trise", trise_cnt, 0);
    check("R1 duty", duty_flag, 0);
    check("R1 err", cfg_err, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TV[i][0], TV[i][1], TV[i][2], TV[i][3]);
      check($sformatf("vec%0d div", i),   div_val,   TV[i][4]);
      check($sformatf("vec%0d trise", i), trise_cnt, TV[i][5]);
      check($sformatf("vec%0d duty", i),  duty_flag, TV[i][6]);
      check($sformatf("vec%0d err", i),   cfg_err,   TV[i][7]);
      if (TV[i][8] != 0) begin
        measure(lo, hi);
        check($sformatf("vec%0d low", i),  lo, TV[i][8]);
        check($sformatf("vec%0d high", i), hi, TV[i][9]);
      end
      if (TV[i][7] != 0) begin
        // R7 R8: no clock while the configuration is in error
        int lows = 0;
        enable = 1'b1;
        repeat (30) begin @(negedge clk); if (!scl) lows++; end
        enable = 1'b0;
        check($sformatf("vec%0d R7 scl held", i), lows, 0);
      end
    end

    // R10: changes while enabled are ignored
    apply(8, 100, 0, 0);
    enable = 1'b1;
    @(negedge clk);
    clk_mhz = 6'd36; bus_khz = 9'd400; fast_mode = 1;
    repeat (60) @(negedge clk);
    check("R10 div frozen", div_val, 40);
    check("R10 trise frozen", trise_cnt, 9);
    enable = 1'b0;
    @(negedge clk);
    check("R11 scl idle", scl, 1);
    repeat (60) @(negedge clk);
    check("R10 div updated", div_val, 30);
    check("R10 trise updated", trise_cnt, 11);
    measure(lo, hi);
    check("R10 low after update", lo, 60);

    // R11: first cycle after enable is low
    enable = 1'b1;
    @(negedge clk);
    check("R11 first low", scl, 0);
    enable = 1'b0;
    repeat (3) @(negedge clk);

    // R12: stretch in low phase extends it, in high phase does nothing
    apply(4, 400, 1, 0);
    enable = 1'b1;
    @(negedge clk);
    lo = 1;
    stretch = 1'b1;
    repeat (5) begin @(negedge clk); if (!scl) lo++; end
    stretch = 1'b0;
    @(negedge clk);
    while (!scl) begin lo++; @(negedge clk); end
    check("R12 stretched low", lo, 11);
    hi = 0;
    stretch = 1'b1;
    while (scl && hi < 1000) begin hi++; @(negedge clk); end
    stretch = 1'b0;
    check("R12 high unaffected", hi, 3);
    enable = 1'b0;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule